// File: doc/BRIEF.md
# Compressed Instruction Mode Sequencer

This block follows the encoding mode of an instruction stream in which 32-bit standard instructions are interleaved with 16-bit compressed parcels. Each valid item is classified in the cycle it is presented. The classes are a standard instruction, a 10-bit compressed form, a 16-bit compressed form or a 16-bit immediate form. The block also flags illegal, nop and attention parcels. On the clock edge it then updates the mode that applies to the next item.

Bits are numbered 0 (most significant) to 15 (least significant) within a parcel. Doc bit k is `parcel[15-k]`. Mode control sits in two trailing bits of each compressed parcel. N is bit 0 (`parcel[15]`) and M is bit 15 (`parcel[0]`). One combination runs a single standard instruction and then falls back to 16-bit mode. Opcode decode, register access and fetch alignment live elsewhere. Outputs are combinational from the current mode and the presented item.

Top module: `cmode_seq`

## Requirements
- R1: A synchronous reset places the sequencer in standard mode, so that the first valid parcel with a nonzero bits 0-4 is classified standard (fmt = 2'b00).
- R2: In standard mode, a valid item with `in_word` low and bits 0-4 (`parcel[15:11]`) all zero is a 10-bit form (fmt = 2'b01). Any other item is standard (fmt = 2'b00), and this includes every item with `in_word` high. A standard item leaves the mode unchanged.
- R3: After a non-illegal 10-bit form, the next item is handled in 16-bit mode if M (`parcel[0]`) is 1, and in standard mode if M is 0.
- R4: In 16-bit mode every valid item is a 16-bit form (fmt = 2'b10). (N, M) = 01 keeps 16-bit mode. (N, M) = 00 returns to standard mode.
- R5: In 16-bit mode, (N, M) = 10 makes exactly the next item standard (fmt = 2'b00), whatever its bits. The item after that is handled in 16-bit mode.
- R6: In 16-bit mode, (N, M) = 11 classifies the parcel as the immediate form (fmt = 2'b11), and 16-bit mode is kept.
- R7: In 16-bit mode, a parcel whose major.minor field (`parcel[10:7]`) is 4'b0011 is a 16-bit form even when N = 1. The next mode depends on M alone: 1 keeps 16-bit mode and 0 returns to standard mode.
- R8: An all-zero parcel in 10-bit or 16-bit form raises `illegal` for that item only, and the next item is handled in standard mode.
- R9: `nop` is raised for 16'h0001 as a 10-bit or 16-bit form, and for 16'h8000 as a 16-bit form.
- R10: `attn` is raised for 16'hC000 as a 16-bit form.
- R11: While `in_valid` is low all outputs are zero and the mode does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Item present this cycle |
| in_word | input | 1 | Item is a full 32-bit standard word (upper half on `parcel`) |
| parcel | input | 16 | Parcel, `parcel[15]` is bit 0 |
| fmt | output | 2 | Class: 00 standard, 01 10-bit, 10 16-bit, 11 immediate |
| illegal | output | 1 | All-zero compressed parcel |
| nop | output | 1 | Compressed nop |
| attn | output | 1 | Attention parcel |

## Verification
The bench drives the single-shot exit with a follow-up parcel that would read as a 10-bit form. A sequencer that ignored the single-shot state would misclassify that parcel or stay in standard mode. The 0011 sub-encoding is sent with N = 1 and M = 1. A decoder missing the exception would report the immediate class there, and with N = 1 and M = 0 it would enter the single-shot state. All-zero parcels are sent in both compressed modes, and nothing that follows them may remain in 16-bit mode. Mode-changing parcels are also held on the bus while `in_valid` is low, which catches a sequencer that steps on unqualified input.

// File: rtl/cmode_seq.sv
module cmode_seq (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic        in_word,
  input  logic [15:0] parcel,
  output logic [1:0]  fmt,
  output logic        illegal,
  output logic        nop,
  output logic        attn
);
  typedef enum logic [1:0] {M_STD = 2'd0, M_C16 = 2'd1, M_ONE = 2'd2} mode_t;

  localparam logic [1:0] F_STD = 2'b00;
  localparam logic [1:0] F_C10 = 2'b01;
  localparam logic [1:0] F_C16 = 2'b10;
  localparam logic [1:0] F_IMM = 2'b11;

  mode_t mode, mode_nx;

  wire bit_n   = parcel[15];
  wire bit_m   = parcel[0];
  wire hi_zero = (parcel[15:11] == 5'd0);
  wire sub_enc = (parcel[10:7] == 4'b0011);
  wire all_z   = (parcel == 16'h0000);

  always_comb begin
    fmt     = F_STD;
    illegal = 1'b0;
    nop     = 1'b0;
    attn    = 1'b0;
    mode_nx = mode;
    if (in_valid) begin
      case (mode)
        M_STD: begin
          if (hi_zero && !in_word) begin
            fmt     = F_C10;
            illegal = all_z;
            nop     = (parcel == 16'h0001);
            mode_nx = (bit_m && !all_z) ? M_C16 : M_STD;
          end
        end
        M_ONE: mode_nx = M_C16;
        default: begin
          fmt     = F_C16;
          illegal = all_z;
          nop     = (parcel == 16'h0001) || (parcel == 16'h8000);
          attn    = (parcel == 16'hC000);
          if (all_z)
            mode_nx = M_STD;
          else if (sub_enc)
            mode_nx = bit_m ? M_C16 : M_STD;
          else begin
            case ({bit_n, bit_m})
              2'b00: mode_nx = M_STD;
              2'b01: mode_nx = M_C16;
              2'b10: mode_nx = M_ONE;
              default: begin
                fmt     = F_IMM;
                mode_nx = M_C16;
              end
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mode <= M_STD;
    else     mode <= mode_nx;
  end

  a_r11_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(mode));
  a_r8_illegal_to_std: assert property (@(posedge clk) disable iff (rst)
    illegal |=> (mode == M_STD));
  a_r5_single_standard: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == M_ONE) |-> (fmt == F_STD && !illegal && !nop && !attn));
  a_r6_imm_stays: assert property (@(posedge clk) disable iff (rst)
    (fmt == F_IMM) |=> (mode == M_C16));
  a_r3_c10_entry: assert property (@(posedge clk) disable iff (rst)
    (fmt == F_C10 && parcel[0] && !illegal) |=> (mode == M_C16));
  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({illegal, nop, attn}));
endmodule

// File: tb/cmode_seq_bench.sv
module cmode_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_word = 1'b0;
  logic [15:0] parcel = 16'h0000;
  logic [1:0]  fmt;
  logic        illegal, nop, attn;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  cmode_seq u_cmode_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .parcel(parcel), .fmt(fmt), .illegal(illegal), .nop(nop), .attn(attn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step(input logic v, input logic w, input logic [15:0] p,
                      input logic [1:0] ef, input logic ei, input logic en,
                      input logic ea, input string tag);
    @(negedge clk);
    in_valid = v; in_word = w; parcel = p;
    #(CLK_PERIOD/4);
    checks++;
    if (fmt !== ef || illegal !== ei || nop !== en || attn !== ea) begin
      failures++;
      $display("FAIL %s parcel=%h actual fmt=%b ill=%b nop=%b attn=%b expected fmt=%b ill=%b nop=%b attn=%b",
               tag, p, fmt, illegal, nop, attn, ef, ei, en, ea);
    end
  endtask

  task automatic enter_c16();
    step(1, 0, 16'h0101, 2'b01, 0, 0, 0, "R3 enter");
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    step(0, 0, 16'h0101, 2'b00, 0, 0, 0, "R11 idle after reset");
    step(1, 0, 16'h4000, 2'b00, 0, 0, 0, "R1 reset mode standard");
  endtask

  task automatic t_standard();
    step(1, 0, 16'h0100, 2'b01, 0, 0, 0, "R2 10-bit detect");
    step(1, 1, 16'h0100, 2'b00, 0, 0, 0, "R2 word flag standard");
    step(1, 0, 16'h4000, 2'b00, 0, 0, 0, "R2 nonzero top standard");
    step(1, 0, 16'h0000, 2'b01, 1, 0, 0, "R8 illegal 10-bit");
    step(1, 0, 16'h4000, 2'b00, 0, 0, 0, "R8 standard after illegal");
  endtask

  task automatic t_c10_and_illegal();
    enter_c16();
    step(1, 0, 16'h0101, 2'b10, 0, 0, 0, "R3 M=1 gives 16-bit");
    step(1, 0, 16'h0000, 2'b10, 1, 0, 0, "R8 illegal 16-bit");
    step(1, 0, 16'h4000, 2'b00, 0, 0, 0, "R8 standard after 16-bit illegal");
  endtask

  task automatic t_exit();
    enter_c16();
    step(1, 0, 16'h4100, 2'b10, 0, 0, 0, "R4 NM=00");
    step(1, 0, 16'h0100, 2'b01, 0, 0, 0, "R4 back to standard");
  endtask

  task automatic t_single();
    enter_c16();
    step(1, 0, 16'h8100, 2'b10, 0, 0, 0, "R5 NM=10");
    step(1, 0, 16'h0100, 2'b00, 0, 0, 0, "R5 one standard item");
    step(1, 0, 16'h0100, 2'b10, 0, 0, 0, "R5 returns to 16-bit");
  endtask

  task automatic t_imm();
    enter_c16();
    step(1, 0, 16'h8101, 2'b11, 0, 0, 0, "R6 immediate class");
    step(1, 0, 16'h0101, 2'b10, 0, 0, 0, "R6 stays 16-bit");
    step(1, 0, 16'h4100, 2'b10, 0, 0, 0, "R4 exit");
  endtask

  task automatic t_sub();
    enter_c16();
    step(1, 0, 16'h8180, 2'b10, 0, 0, 0, "R7 sub M=0");
    step(1, 0, 16'h0100, 2'b01, 0, 0, 0, "R7 standard not single");
    enter_c16();
    step(1, 0, 16'h8181, 2'b10, 0, 0, 0, "R7 sub not immediate");
    step(1, 0, 16'h0101, 2'b10, 0, 0, 0, "R7 stays 16-bit");
    step(1, 0, 16'h4100, 2'b10, 0, 0, 0, "R4 exit");
  endtask

  task automatic t_nop_attn();
    step(1, 0, 16'h0001, 2'b01, 0, 1, 0, "R9 10-bit nop");
    step(1, 0, 16'h0001, 2'b10, 0, 1, 0, "R9 16-bit nop low");
    step(1, 0, 16'h8000, 2'b10, 0, 1, 0, "R9 16-bit nop high");
    step(1, 0, 16'h4000, 2'b00, 0, 0, 0, "R5 after nop");
    step(1, 0, 16'hC000, 2'b10, 0, 0, 1, "R10 attn");
    step(1, 1, 16'h4000, 2'b00, 0, 0, 0, "R5 after attn");
    step(1, 0, 16'h0000, 2'b10, 1, 0, 0, "R8 illegal exit");
  endtask

  task automatic t_idle();
    enter_c16();
    for (int i = 0; i < 3; i++)
      step(0, 0, 16'h4100, 2'b00, 0, 0, 0, "R11 idle outputs");
    step(1, 0, 16'h0101, 2'b10, 0, 0, 0, "R11 mode held 16-bit");
    step(1, 0, 16'h4100, 2'b10, 0, 0, 0, "R4 exit");
    step(0, 0, 16'h0101, 2'b00, 0, 0, 0, "R11 idle in standard");
    step(1, 0, 16'h4000, 2'b00, 0, 0, 0, "R11 mode held standard");
  endtask

  initial begin
    t_reset();
    t_standard();
    t_c10_and_illegal();
    t_exit();
    t_single();
    t_imm();
    t_sub();
    t_nop_attn();
    t_idle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule